// File: doc/BRIEF.md
# Sparse Rectangle Readout Sequencer

This block drives the analog-to-digital readout of a pixel array whose values have just been averaged over a grid of equal rectangles. Every pixel inside one rectangle holds the same value, so converting one representative pixel per rectangle is enough. The sequencer emits one conversion request per rectangle: the row and column of the rectangle's top-left pixel, plus a tag holding the index of the processing step. It walks the rectangles in raster order, column fastest. The address stride equals the current rectangle side, so the number of conversions falls as the rectangles grow.

A readout pass follows the capture, where the side is 1 and every pixel is read. Another pass follows each averaging step, where the side comes from the active progression (4, 8, 16, ... or 6, 12, 24, ...). Each averaging step destroys the previous image representation. For that reason the block raises a one-cycle completion pulse only after the last conversion has been accepted, and the grid controller must wait for this pulse before it applies the next grid.

Conversion requests leave on a valid/ready stream. Once `req_valid_o` is high, it stays high, and the address, tag and last flag stay unchanged, until the converter raises `req_ready_i`. A request is transferred on every clock edge where both are high. `req_ready_i` may be held low for any number of cycles, and the sequence then stalls without losing or repeating a request. Ready may be high while valid is low; it has no effect then.

Top module: `rect_readout_seq`

## Requirements
- R1: During reset and at its release, `req_valid_o` and `done_o` are low.
- R2: A `start_i` pulse seen while the block is idle (no request pending, no completion pulse) latches `side_i`, `rows_i`, `cols_i` and `step_i`. On the next cycle the first request is valid at row 0, column 0, and `req_step_o` equals the latched step.
- R3: Requests walk the rectangles in raster order with the column fastest. Columns take the values 0, s, 2s, ... below the column count, and rows take 0, s, 2s, ... below the row count, where s is the latched side. A partial rectangle at the right or bottom edge is requested at its top-left pixel.
- R4: A latched side of 1 requests every pixel. A side of 0 is treated as 1.
- R5: One pass issues exactly ceil(rows/s) * ceil(cols/s) transfers.
- R6: While `req_valid_o` is high and `req_ready_i` is low, the request stays valid with the same address, tag and last flag on the next cycle.
- R7: `req_last_o` is high only together with `req_valid_o`, and only on the final request of a pass.
- R8: `done_o` is high for exactly one cycle, the cycle after the final transfer. No request is valid in that cycle.
- R9: `start_i` during a pass or during the completion cycle is ignored. Changes to `side_i`, `rows_i`, `cols_i` or `step_i` after the start do not alter the pass in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a readout pass when idle |
| side_i | input | SIDE_W | Rectangle side for the pass (0 read as 1) |
| step_i | input | STEP_W | Step index used to tag the samples |
| rows_i | input | ROW_W | Array height in pixels (nonzero) |
| cols_i | input | COL_W | Array width in pixels (nonzero) |
| req_valid_o | output | 1 | Conversion request valid |
| req_ready_i | input | 1 | Converter accepts the request |
| req_row_o | output | ROW_W | Row of the representative pixel |
| req_col_o | output | COL_W | Column of the representative pixel |
| req_step_o | output | STEP_W | Step tag of the request |
| req_last_o | output | 1 | Marks the final request of the pass |
| done_o | output | 1 | One-cycle readout-complete pulse |

## Verification
The bound checker watches several properties on every cycle: requests hold stable under back-pressure, every address lies inside the latched array, and each transfer moves either one stride right or wraps to column 0 one stride down. It also checks that the first request of a pass is at the origin, that every request carries the latched tag, and that the completion pulse lasts one cycle and comes only right after a final transfer. Some behaviour only the bench scenarios can show, because it needs a whole pass checked against an independent model. This covers the exact number of transfers, the raster order across the whole pass, the handling of partial edge rectangles and of side values 0 and 1, and the fact that starts and input changes during a pass or during the completion cycle are ignored.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DONE = 2'd2
  } rrs_state_e;
endpackage

// File: rtl/rrs_cfg.sv
module rrs_cfg #(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int SIDE_W = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SIDE_W-1:0] side_in,
  input  logic [STEP_W-1:0] step_in,
  input  logic [ROW_W-1:0]  rows_in,
  input  logic [COL_W-1:0]  cols_in,
  output logic [ROW_W-1:0]  row_stride,
  output logic [COL_W-1:0]  col_stride,
  output logic [STEP_W-1:0] step_q,
  output logic [ROW_W-1:0]  rows_q,
  output logic [COL_W-1:0]  cols_q
);
  logic [SIDE_W-1:0] side_eff;
  logic [SIDE_W-1:0] side_q;

  // a zero side is read as one pixel
  always_comb begin
    side_eff = side_in;
    if (side_in == '0) side_eff = SIDE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_q <= SIDE_W'(1);
      step_q <= '0;
      rows_q <= ROW_W'(1);
      cols_q <= COL_W'(1);
    end else if (load) begin
      side_q <= side_eff;
      step_q <= step_in;
      rows_q <= rows_in;
      cols_q <= cols_in;
    end
  end

  assign row_stride = ROW_W'(side_q);
  assign col_stride = COL_W'(side_q);
endmodule

// File: rtl/rrs_axis.sv
module rrs_axis #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         adv,
  input  logic [W-1:0] stride,
  input  logic [W-1:0] limit,
  output logic [W-1:0] pos,
  output logic         at_end
);
  logic [W:0] nxt;

  assign nxt    = {1'b0, pos} + {1'b0, stride};
  assign at_end = (nxt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= '0;
    else if (clear)  pos <= '0;
    else if (adv)    pos <= at_end ? '0 : nxt[W-1:0];
  end
endmodule

// File: rtl/rrs_fsm.sv
module rrs_fsm
  import rrs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic xfer,
  input  logic final_xfer,
  output logic load,
  output logic valid,
  output logic done
);
  rrs_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_REQ;
      ST_REQ:  if (final_xfer) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign load  = (st_q == ST_IDLE) && start;
  assign valid = (st_q == ST_REQ);
  assign done  = (st_q == ST_DONE);

  logic unused_xfer;
  assign unused_xfer = xfer;
endmodule

// File: rtl/rect_readout_seq.sv
module rect_readout_seq #(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int SIDE_W = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SIDE_W-1:0] side_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [ROW_W-1:0]  rows_i,
  input  logic [COL_W-1:0]  cols_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ROW_W-1:0]  req_row_o,
  output logic [COL_W-1:0]  req_col_o,
  output logic [STEP_W-1:0] req_step_o,
  output logic              req_last_o,
  output logic              done_o
);
  logic              load, valid, xfer, final_xfer;
  logic              row_end, col_end;
  logic [ROW_W-1:0]  row_stride, rows_q, row_pos;
  logic [COL_W-1:0]  col_stride, cols_q, col_pos;
  logic [STEP_W-1:0] step_q;

  rrs_cfg #(.ROW_W(ROW_W), .COL_W(COL_W), .SIDE_W(SIDE_W), .STEP_W(STEP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .side_in(side_i), .step_in(step_i), .rows_in(rows_i), .cols_in(cols_i),
    .row_stride(row_stride), .col_stride(col_stride),
    .step_q(step_q), .rows_q(rows_q), .cols_q(cols_q)
  );

  // column runs fastest; row steps when the column wraps
  rrs_axis #(.W(COL_W)) u_col (
    .clk(clk), .rst_n(rst_n), .clear(load), .adv(xfer),
    .stride(col_stride), .limit(cols_q), .pos(col_pos), .at_end(col_end)
  );

  rrs_axis #(.W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .clear(load), .adv(xfer && col_end),
    .stride(row_stride), .limit(rows_q), .pos(row_pos), .at_end(row_end)
  );

  rrs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start_i), .xfer(xfer),
    .final_xfer(final_xfer), .load(load), .valid(valid), .done(done_o)
  );

  assign xfer        = valid && req_ready_i;
  assign final_xfer  = xfer && row_end && col_end;
  assign req_valid_o = valid;
  assign req_row_o   = row_pos;
  assign req_col_o   = col_pos;
  assign req_step_o  = step_q;
  assign req_last_o  = valid && row_end && col_end;
endmodule

// File: rtl/rect_readout_seq_chk.sv
module rect_readout_seq_chk #(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int SIDE_W = 8,
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [SIDE_W-1:0] side_i,
  input logic [STEP_W-1:0] step_i,
  input logic [ROW_W-1:0]  rows_i,
  input logic [COL_W-1:0]  cols_i,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ROW_W-1:0]  req_row_o,
  input logic [COL_W-1:0]  req_col_o,
  input logic [STEP_W-1:0] req_step_o,
  input logic              req_last_o,
  input logic              done_o
);
  logic              idle;
  int                c_side, c_rows, c_cols;
  logic [STEP_W-1:0] c_step;

  assign idle = !req_valid_o && !done_o;

  // independent copy of the pass configuration, taken at an idle start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_side <= 1; c_rows <= 1; c_cols <= 1; c_step <= '0;
    end else if (start_i && idle) begin
      c_side <= (side_i == '0) ? 1 : int'(side_i);
      c_rows <= int'(rows_i);
      c_cols <= int'(cols_i);
      c_step <= step_i;
    end
  end

  always @(posedge clk)
    if (!rst_n) assert_reset_quiet_R1: assert (!req_valid_o && !done_o);

  assert_first_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && idle |=> req_valid_o && req_row_o == '0 && req_col_o == '0);

  assert_step_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> req_step_o == c_step);

  assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> int'(req_row_o) < c_rows && int'(req_col_o) < c_cols);

  assert_raster_stride_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_ready_i && !req_last_o |=> req_valid_o &&
      ((int'(req_col_o) == int'($past(req_col_o)) + c_side && req_row_o == $past(req_row_o)) ||
       (req_col_o == '0 && int'(req_row_o) == int'($past(req_row_o)) + c_side)));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_row_o) && $stable(req_col_o)
      && $stable(req_step_o) && $stable(req_last_o));

  assert_last_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_last_o |-> req_valid_o);

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_ready_i && req_last_o |=> done_o && !req_valid_o);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(req_valid_o && req_ready_i && req_last_o));
endmodule

bind rect_readout_seq rect_readout_seq_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .SIDE_W(SIDE_W), .STEP_W(STEP_W)
) u_chk (.*);

// File: tb/tb_rect_readout_seq.sv
module tb_rect_readout_seq;
  localparam int ROW_W = 10, COL_W = 10, SIDE_W = 8, STEP_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, req_ready_i = 1'b0;
  logic [SIDE_W-1:0] side_i = '0;
  logic [STEP_W-1:0] step_i = '0;
  logic [ROW_W-1:0]  rows_i = ROW_W'(1);
  logic [COL_W-1:0]  cols_i = COL_W'(1);
  logic req_valid_o, req_last_o, done_o;
  logic [ROW_W-1:0]  req_row_o;
  logic [COL_W-1:0]  req_col_o;
  logic [STEP_W-1:0] req_step_o;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int unsigned seed_dummy;

  always #2 clk = ~clk;

  rect_readout_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .SIDE_W(SIDE_W), .STEP_W(STEP_W)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 180000);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic run_pass(input int side, input int rows, input int cols, input int step,
                          input int rdy_pct, input bit noise);
    int s, er, ec, ntx, exp_n;
    bit rdy, exp_last, finished;
    s = (side == 0) ? 1 : side;
    exp_n = ceil_div(rows, s) * ceil_div(cols, s);
    er = 0; ec = 0; ntx = 0; finished = 0;
    @(negedge clk);
    chk(!req_valid_o && !done_o, "R9 idle before start", int'(req_valid_o), 0);
    start_i = 1'b1;
    side_i = SIDE_W'(side); rows_i = ROW_W'(rows); cols_i = COL_W'(cols); step_i = STEP_W'(step);
    @(negedge clk);
    start_i = 1'b0;
    for (int it = 0; it < 20000 && !finished; it++) begin
      exp_last = (er + s >= rows) && (ec + s >= cols);
      chk(req_valid_o == 1'b1, "R6 valid held in pass", int'(req_valid_o), 1);
      chk(int'(req_row_o) == er, "R3 row address", int'(req_row_o), er);
      chk(int'(req_col_o) == ec, "R3 col address", int'(req_col_o), ec);
      chk(int'(req_step_o) == step, "R2 step tag", int'(req_step_o), step);
      chk(req_last_o == exp_last, "R7 last flag", int'(req_last_o), int'(exp_last));
      if (noise) begin
        start_i = ($urandom % 4) == 0;
        side_i  = SIDE_W'($urandom);
        rows_i  = ROW_W'($urandom);
        cols_i  = COL_W'($urandom);
        step_i  = STEP_W'($urandom);
      end
      rdy = ($urandom % 100) < rdy_pct;
      req_ready_i = rdy;
      @(negedge clk);
      if (rdy) begin
        ntx++;
        if (exp_last) finished = 1;
        else if (ec + s >= cols) begin ec = 0; er = er + s; end
        else ec = ec + s;
      end
    end
    req_ready_i = 1'b0;
    chk(done_o == 1'b1, "R8 done after last transfer", int'(done_o), 1);
    chk(req_valid_o == 1'b0, "R8 no request in done cycle", int'(req_valid_o), 0);
    chk(ntx == exp_n, "R5 transfer count", ntx, exp_n);
    start_i = noise;  // start during the completion cycle must be ignored
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b0, "R8 done is one cycle", int'(done_o), 0);
    chk(req_valid_o == 1'b0, "R9 start in done cycle ignored", int'(req_valid_o), 0);
  endtask

  initial begin
    int sides[8];
    sides = '{1, 2, 4, 6, 8, 12, 16, 24};
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(!req_valid_o && !done_o, "R1 quiet in reset", int'(req_valid_o || done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid_o && !done_o, "R1 quiet after reset", int'(req_valid_o || done_o), 0);

    run_pass(0, 3, 5, 2, 100, 0);    // R4 side zero read as one
    run_pass(1, 4, 6, 0, 50, 0);     // R4 capture reads every pixel
    run_pass(4, 10, 10, 1, 70, 0);   // R3 partial edge rectangles
    run_pass(6, 24, 24, 3, 40, 1);   // R9 noise on inputs mid-pass
    run_pass(48, 20, 20, 5, 30, 1);  // single rectangle covering the array
    run_pass(1, 1, 1, 7, 100, 0);    // smallest array
    run_pass(8, 17, 33, 9, 20, 0);   // R6 heavy back-pressure

    for (int k = 0; k < 16; k++)
      run_pass(sides[$urandom % 8], 1 + int'($urandom % 32), 1 + int'($urandom % 32),
               int'($urandom % 16), 20 + int'($urandom % 81), ($urandom % 2) == 1);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule